// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus whose data line is stuck low. The usual cause is a target that was reset partway through a byte and still drives its next data bit low. The main controller starts the sequencer with a single-cycle trigger. The sequencer then takes both open-drain lines and clocks SCL until the target finishes its byte and lets SDA go. The number of pulses is bounded. After the pulse that frees SDA, it builds a clean STOP condition and raises a completion flag, which tells the controller to reinitialise its transfer logic. If SDA is still low after the last allowed pulse, or if another device holds SCL low for too long, the sequencer releases both lines and raises a failure flag.

The sequencer never drives a line high. It only pulls a line low or releases it. All timing is counted in periods of an external tick strobe. Each SCL low phase and high phase lasts a fixed number of ticks. The high phase starts when SCL is actually seen high, so a target that stretches the clock simply slows the sequence down, up to a timeout.

Top module: `i2c_bus_unstick`

## Requirements
- R1: Out of reset, both pull-low outputs, `done_o` and `failed_o` are 0, so both lines are released.
- R2: The block only pulls lines low (`scl_pull_o`/`sda_pull_o` = 1 means pull low). While it is pulsing, it never pulls SDA. At the end of any recovery, both pull outputs are 0.
- R3: Each pulse is a low phase followed by a high phase. SDA is sampled at the end of each high phase, and pulsing stops at the first pulse that reads SDA high. A target that releases SDA after H more clocks therefore sees H+1 pulses, up to MAX_PULSES (default 9).
- R4: While SCL is high on the bus, the block never makes SDA fall. No START condition appears during recovery.
- R5: On success, the STOP is made in this order: SCL pulled low, SDA pulled low, SCL released (and seen high), SDA released. This gives exactly one SDA rise while SCL is high.
- R6: After the STOP, `done_o` is set and `failed_o` stays 0. Both flags hold their value until the next accepted start.
- R7: If SDA still reads low at the end of pulse MAX_PULSES, `failed_o` is set, both lines are released and no STOP is made.
- R8: Each phase that the block times, such as the SCL low phase, lasts exactly PHASE_TICKS tick strobes.
- R9: After it releases SCL, the block waits until the line reads high before it starts the high phase. A clock stretch shorter than WAIT_TICKS ticks does not change the result.
- R10: If SCL stays low for WAIT_TICKS ticks after release, the block sets `failed_o` and releases both lines.
- R11: A start pulse while recovery is running is ignored. A start pulse while idle clears both flags and begins a new recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle recovery trigger |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| tick_i | input | 1 | One-cycle timing strobe |
| scl_pull_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| done_o | output | 1 | Recovery finished with STOP; reinitialise the controller |
| failed_o | output | 1 | Recovery gave up (SDA stuck or SCL held) |

## Verification
A bus model in the bench plays a target that keeps SDA low for a chosen number of further clocks and lets go on an SCL falling edge. The bench runs it with values of zero, the largest count that still succeeds, and one past it, plus random counts. Together these show whether the pulse counting stops at the first high sample and whether the pulse limit falls at the right boundary. A monitor on the bus counts SCL rises, START events and STOP events, which separates a correct STOP from a glitch or a missing release. Random clock stretches below the timeout and a permanent hold tell patient waiting apart from a timeout. An extra trigger in the middle of a run checks that it has no effect.

// File: rtl/i2cu_pkg.sv
package i2cu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE_LO,
        ST_PULSE_WAIT,
        ST_PULSE_HI,
        ST_STOP_CLK_LO,
        ST_STOP_DAT_LO,
        ST_STOP_WAIT,
        ST_STOP_CLK_HI,
        ST_STOP_DAT_HI
    } rec_state_e;

    typedef enum logic [1:0] {
        FIN_NONE,
        FIN_DONE,
        FIN_FAIL
    } finish_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pull_t;

    // Line pull pattern for each state: 1 means pull low.
    function automatic pull_t pulls_for(rec_state_e s);
        pull_t p;
        p.scl = 1'b0;
        p.sda = 1'b0;
        case (s)
            ST_PULSE_LO:    p.scl = 1'b1;
            ST_STOP_CLK_LO: p.scl = 1'b1;
            ST_STOP_DAT_LO: begin p.scl = 1'b1; p.sda = 1'b1; end
            ST_STOP_WAIT:   p.sda = 1'b1;
            ST_STOP_CLK_HI: p.sda = 1'b1;
            default:        ;
        endcase
        return p;
    endfunction

    // States whose length is a fixed number of ticks.
    function automatic logic is_timed(rec_state_e s);
        return (s == ST_PULSE_LO)    || (s == ST_PULSE_HI)    ||
               (s == ST_STOP_CLK_LO) || (s == ST_STOP_DAT_LO) ||
               (s == ST_STOP_CLK_HI) || (s == ST_STOP_DAT_HI);
    endfunction

    // States that wait for SCL to read high after release.
    function automatic logic is_wait(rec_state_e s);
        return (s == ST_PULSE_WAIT) || (s == ST_STOP_WAIT);
    endfunction

endpackage

// File: rtl/i2cu_tick_timer.sv
module i2cu_tick_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign expired_o = run_i && tick_i && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the count never passes the phase length while its state runs
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < W'(LIMIT)));

endmodule

// File: rtl/i2cu_pulse_ctr.sv
module i2cu_pulse_ctr #(
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned W = $clog2(MAX_PULSES + 1);

    logic [W-1:0] cnt_q;

    // True while the pulse being finished is the final one allowed.
    assign last_o = (cnt_q == W'(MAX_PULSES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> (cnt_q < W'(MAX_PULSES)));

endmodule

// File: rtl/i2cu_rec_fsm.sv
module i2cu_rec_fsm
    import i2cu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       phase_exp_i,
    input  logic       wait_exp_i,
    input  logic       last_pulse_i,
    output rec_state_e state_o,
    output logic       timer_clr_o,
    output logic       pulse_clr_o,
    output logic       pulse_inc_o,
    output logic       done_o,
    output logic       failed_o
);
    rec_state_e state_q, state_d;
    finish_e    fin;
    logic       done_q, failed_q;

    always_comb begin
        state_d     = state_q;
        fin         = FIN_NONE;
        pulse_inc_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PULSE_LO;
            end
            ST_PULSE_LO: begin
                if (phase_exp_i) state_d = ST_PULSE_WAIT;
            end
            ST_PULSE_WAIT: begin
                if (scl_i) begin
                    state_d = ST_PULSE_HI;
                end else if (wait_exp_i) begin
                    state_d = ST_IDLE;
                    fin     = FIN_FAIL;
                end
            end
            ST_PULSE_HI: begin
                if (phase_exp_i) begin
                    pulse_inc_o = 1'b1;
                    if (sda_i) begin
                        state_d = ST_STOP_CLK_LO;
                    end else if (last_pulse_i) begin
                        state_d = ST_IDLE;
                        fin     = FIN_FAIL;
                    end else begin
                        state_d = ST_PULSE_LO;
                    end
                end
            end
            ST_STOP_CLK_LO: begin
                if (phase_exp_i) state_d = ST_STOP_DAT_LO;
            end
            ST_STOP_DAT_LO: begin
                if (phase_exp_i) state_d = ST_STOP_WAIT;
            end
            ST_STOP_WAIT: begin
                if (scl_i) begin
                    state_d = ST_STOP_CLK_HI;
                end else if (wait_exp_i) begin
                    state_d = ST_IDLE;
                    fin     = FIN_FAIL;
                end
            end
            ST_STOP_CLK_HI: begin
                if (phase_exp_i) state_d = ST_STOP_DAT_HI;
            end
            ST_STOP_DAT_HI: begin
                if (phase_exp_i) begin
                    state_d = ST_IDLE;
                    fin     = FIN_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b0;
            failed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                done_q   <= 1'b0;
                failed_q <= 1'b0;
            end else if (fin == FIN_DONE) begin
                done_q <= 1'b1;
            end else if (fin == FIN_FAIL) begin
                failed_q <= 1'b1;
            end
        end
    end

    assign state_o     = state_q;
    assign timer_clr_o = (state_d != state_q);
    assign pulse_clr_o = (state_q == ST_IDLE);
    assign done_o      = done_q;
    assign failed_o    = failed_q;

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_q && failed_q));

    // R6
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(state_q) == ST_STOP_DAT_HI) && (state_q == ST_IDLE));

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import i2cu_pkg::*;
#(
    parameter int unsigned PHASE_TICKS = 4,
    parameter int unsigned WAIT_TICKS  = 64,
    parameter int unsigned MAX_PULSES  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic tick_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic done_o,
    output logic failed_o
);
    rec_state_e state;
    pull_t      pulls;
    logic       timer_clr, pulse_clr, pulse_inc, last_pulse;
    logic       phase_exp, wait_exp;

    i2cu_rec_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .phase_exp_i  (phase_exp),
        .wait_exp_i   (wait_exp),
        .last_pulse_i (last_pulse),
        .state_o      (state),
        .timer_clr_o  (timer_clr),
        .pulse_clr_o  (pulse_clr),
        .pulse_inc_o  (pulse_inc),
        .done_o       (done_o),
        .failed_o     (failed_o)
    );

    i2cu_tick_timer #(.LIMIT(PHASE_TICKS)) u_phase_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (timer_clr),
        .run_i     (is_timed(state)),
        .tick_i    (tick_i),
        .expired_o (phase_exp)
    );

    i2cu_tick_timer #(.LIMIT(WAIT_TICKS)) u_wait_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (timer_clr),
        .run_i     (is_wait(state)),
        .tick_i    (tick_i),
        .expired_o (wait_exp)
    );

    i2cu_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (pulse_clr),
        .inc_i  (pulse_inc),
        .last_o (last_pulse)
    );

    assign pulls      = pulls_for(state);
    assign scl_pull_o = pulls.scl;
    assign sda_pull_o = pulls.sda;

    // R4: SDA is only grabbed while SCL has been held low
    sda_grab_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> scl_pull_o && $past(scl_pull_o));

    // R5: SDA is only let go while SCL is released
    sda_free_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> !scl_pull_o && $past(!scl_pull_o));

    // R7
    fail_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(failed_o) |-> !scl_pull_o && !sda_pull_o);

endmodule

// File: tb/i2c_bus_unstick_tb_top.sv
module i2c_bus_unstick_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PHASE    = 3;
    localparam int WAITT    = 12;
    localparam int MAXP     = 9;
    localparam int TICK_DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic tick_i = 1'b0;
    logic scl_i, sda_i;
    logic scl_pull_o, sda_pull_o, done_o, failed_o;

    // bus model state
    int  hold_n = 0, stretch_n = 0, stretch_cnt = 0;
    bit  tgt_low = 1'b0, stretch_forever = 1'b0;
    int  rises = 0, stops = 0, starts = 0;
    int  ticks_total = 0, div_cnt = 0, low_snap = 0, low_ticks = 0;
    bit  got_low = 1'b0, pull_prev = 1'b0;
    bit  scl_prev = 1'b1, sda_prev = 1'b1;

    int  n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    assign scl_i = !scl_pull_o && !(stretch_cnt > 0 || stretch_forever);
    assign sda_i = !sda_pull_o && !tgt_low;

    i2c_bus_unstick #(
        .PHASE_TICKS(PHASE),
        .WAIT_TICKS (WAITT),
        .MAX_PULSES (MAXP)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .tick_i     (tick_i),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .done_o     (done_o),
        .failed_o   (failed_o)
    );

    // Bus monitor, stuck target, clock stretcher and tick source.
    always @(negedge clk) begin
        bit sl, dl;
        sl = scl_i;
        dl = sda_i;
        if (sl && !scl_prev) rises++;
        if (dl && !sda_prev && sl && scl_prev) stops++;
        if (!dl && sda_prev && sl && scl_prev) starts++;
        if (!sl && scl_prev && rises >= hold_n) tgt_low = 1'b0;
        if (scl_pull_o && !pull_prev && !got_low) low_snap = ticks_total;
        if (!scl_pull_o && pull_prev && !got_low) begin
            low_ticks = ticks_total - low_snap;
            got_low   = 1'b1;
        end
        if (scl_pull_o) stretch_cnt = stretch_n;
        else if (tick_i && stretch_cnt > 0) stretch_cnt--;
        pull_prev = scl_pull_o;
        scl_prev  = sl;
        sda_prev  = dl;
        div_cnt++;
        if (div_cnt == TICK_DIV) begin
            div_cnt = 0;
            tick_i  = 1'b1;
            ticks_total++;
        end else begin
            tick_i = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int h);
        return (h + 1 <= MAXP) ? h + 1 : MAXP;
    endfunction

    function automatic bit exp_ok(input int h);
        return (h + 1 <= MAXP);
    endfunction

    task automatic run_case(input int h, input int s, input bit hold_scl, input bit poke);
        int n;
        hold_n          = h;
        tgt_low         = (h > 0);
        stretch_n       = s;
        stretch_forever = hold_scl;
        repeat (3) @(negedge clk);
        rises   = 0;
        stops   = 0;
        starts  = 0;
        got_low = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R11: accepted start clears both flags
        chk("R11", "flags cleared by start", int'(done_o) + int'(failed_o), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!(done_o || failed_o) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        if (hold_scl) begin
            chk("R10", "failed after SCL hold", int'(failed_o), 1);
            chk("R10", "done after SCL hold", int'(done_o), 0);
            chk("R10", "SCL rises during hold", rises, 0);
            chk("R10", "pulls released", int'(scl_pull_o) + int'(sda_pull_o), 0);
        end else begin
            chk(exp_ok(h) ? "R6" : "R7", "done flag", int'(done_o), int'(exp_ok(h)));
            chk(exp_ok(h) ? "R6" : "R7", "failed flag", int'(failed_o), int'(!exp_ok(h)));
            chk(poke ? "R11" : (s > 0 ? "R9" : "R3"), "SCL rises on bus",
                rises, exp_pulses(h) + (exp_ok(h) ? 1 : 0));
            chk("R5", "STOP count", stops, exp_ok(h) ? 1 : 0);
            chk("R4", "START count", starts, 0);
            chk("R2", "pulls released at end", int'(scl_pull_o) + int'(sda_pull_o), 0);
            chk("R8", "first low phase ticks", got_low ? low_ticks : -1, PHASE);
        end
        // R6: flags hold until the next start
        repeat (10) @(negedge clk);
        chk("R6", "flag held",
            int'(done_o) + 2 * int'(failed_o),
            hold_scl ? 2 : (exp_ok(h) ? 1 : 2));
        stretch_forever = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1", "scl pull after reset", int'(scl_pull_o), 0);
        chk("R1", "sda pull after reset", int'(sda_pull_o), 0);
        chk("R1", "done after reset", int'(done_o), 0);
        chk("R1", "failed after reset", int'(failed_o), 0);

        run_case(0, 0, 1'b0, 1'b0);       // R3: free at once, one pulse
        run_case(3, 0, 1'b0, 1'b0);       // R3
        run_case(MAXP - 1, 0, 1'b0, 1'b0); // R3 boundary: last allowed pulse frees SDA
        run_case(MAXP, 0, 1'b0, 1'b0);     // R7 boundary: stuck through all pulses
        run_case(5, 4, 1'b0, 1'b0);       // R9 stretched pulses
        run_case(2, 0, 1'b1, 1'b0);       // R10 SCL held forever
        run_case(4, 0, 1'b0, 1'b1);       // R11 extra start mid-run

        for (int i = 0; i < 14; i++) begin
            int h, s;
            h = int'($urandom_range(0, 11));
            s = int'($urandom_range(0, 6));
            run_case(h, s, 1'b0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule